// File: doc/BRIEF.md
# Dual-Compare Eight-Bit Timer Pair

This block holds two identical eight-bit up-counter channels that draw their count clock from one shared, free-running prescaler. Each channel picks one of three prescaler taps (divide by 8, 64 or 8192) or stops. It compares its counter against two compare registers and keeps three sticky status flags: compare A, compare B and overflow. A compare match can also restart the counter from zero, which turns the channel into a periodic timer.

Software reaches every register over a byte-wide write port and a combinational read port. The register is selected by a channel-select field and a register index. Each flag drives an interrupt request line when its enable bit is set, and an interrupt controller outside the block collects these lines.

Top module: `tmr8_pair`

## Requirements
- R1: Control bits [2:0] select the count tick. Value 1 ticks once every 8 clocks, 2 once every 64, 3 once every 8192, and 0 or 4 to 7 hold the counter. One divider, shared by both channels, starts at zero after reset and increments every clock. A divide-by-2^k tick occurs in the cycle where the low k divider bits are all ones.
- R2: On a tick with no compare clear, the counter increments by one. A tick taken at 0xFF wraps the counter to 0x00 and sets status bit 5 (overflow).
- R3: In every cycle where the counter is at or above compare A, status bit 6 is set. In every cycle where it is at or above compare B, status bit 7 is set.
- R4: Control bits [4:3] pick the clear mode. With 01, a tick taken while the counter is at or above compare A loads 0 instead of incrementing. With 10 the same applies against compare B. With 00 or 11 there is no clear. A clear never sets the overflow flag.
- R5: Status bits 7:5 are sticky. A register write of 0 clears a bit and a write of 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R6: Status bits 4:0, the control register and both compare registers are plain read/write.
- R7: After reset, both compare registers read 0xFF. The counter, control and status registers read 0x00.
- R8: irq_cmpa[n] equals status bit 6 AND control bit 6 of channel n. irq_cmpb[n] equals status bit 7 AND control bit 7. irq_ovf[n] equals status bit 5 AND control bit 5.
- R9: A register write to the counter loads wdata and overrides any tick or clear in the same cycle.
- R10: addr[3] selects the channel and addr[2:0] the register: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter. Indices 5 to 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Channel select [3] and register index [2:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_cmpa | output | 2 | Compare-A interrupt request, one per channel |
| irq_cmpb | output | 2 | Compare-B interrupt request, one per channel |
| irq_ovf | output | 2 | Overflow interrupt request, one per channel |

## Verification
The counter is run on each tap:
- The divide-by-8 tap is used with a low compare A and clear-on-A, which shows whether the period restarts at the compare value.
- The divide-by-64 tap is used with clear-on-B, which separates the two clear modes.
- The divide-by-8192 tap shows whether the slow tap comes from the shared divider.

A run from 0xF0 with the compares at 0xFF separates a true wrap from a compare clear. A counter write placed exactly on a tick cycle shows which source has priority. A long random mix of writes, reads and clock selects is then compared cycle by cycle against a bench model. That mix lets clearing writes collide with hardware flag sets, which shows whether the sticky flags lose events.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 3;

  typedef enum logic [IDX_W-1:0] {
    RG_CTRL = 3'd0,
    RG_STAT = 3'd1,
    RG_CMPA = 3'd2,
    RG_CMPB = 3'd3,
    RG_CNT  = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    CLR_OFF  = 2'b00,
    CLR_ON_A = 2'b01,
    CLR_ON_B = 2'b10,
    CLR_RSV  = 2'b11
  } clr_mode_e;

  // control register fields
  localparam int CT_IE_OVF = 5;
  localparam int CT_IE_A   = 6;
  localparam int CT_IE_B   = 7;
  // status register flags
  localparam int ST_OVF    = 5;
  localparam int ST_A      = 6;
  localparam int ST_B      = 7;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
  parameter int TAP0_LOG2 = 3,
  parameter int TAP1_LOG2 = 6,
  parameter int TAP2_LOG2 = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [2:0] tick_o
);
  localparam int DIV_W = TAP2_LOG2;
  localparam int TAP_LOG2 [3] = '{TAP0_LOG2, TAP1_LOG2, TAP2_LOG2};

  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + {{(DIV_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign tick_o[g] = &div_q[TAP_LOG2[g]-1:0];
  end

  // slower taps are nested in faster ones (R1)
  p_tap_nest_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[2] |-> tick_o[1]);
  p_tap_nest_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o[1] |-> tick_o[0]);
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
  import tmr8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        tick_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o,
  output logic              irq_ovf_o
);
  localparam logic [DATA_W-1:0] ALL1 = {DATA_W{1'b1}};

  logic [DATA_W-1:0] ctrl_q, stat_q, cmpa_q, cmpb_q, cnt_q;
  logic [DATA_W-1:0] ctrl_d, stat_d, cmpa_d, cmpb_d, cnt_d;
  logic              tick_sel, ge_a, ge_b, clr_now, ovf_now, wr_cnt;
  clr_mode_e         mode;

  always_comb begin
    unique case (ctrl_q[2:0])
      3'd1:    tick_sel = tick_i[0];
      3'd2:    tick_sel = tick_i[1];
      3'd3:    tick_sel = tick_i[2];
      default: tick_sel = 1'b0;
    endcase
  end

  always_comb begin
    mode    = clr_mode_e'(ctrl_q[4:3]);
    ge_a    = cnt_q >= cmpa_q;
    ge_b    = cnt_q >= cmpb_q;
    clr_now = tick_sel && (((mode == CLR_ON_A) && ge_a) ||
                           ((mode == CLR_ON_B) && ge_b));
    ovf_now = tick_sel && !clr_now && (cnt_q == ALL1);
    wr_cnt  = wr_en_i && (idx_i == RG_CNT);
  end

  // next-state
  always_comb begin
    ctrl_d = ctrl_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    stat_d = stat_q;
    if (clr_now)       cnt_d = '0;
    else if (tick_sel) cnt_d = cnt_q + {{(DATA_W-1){1'b0}}, 1'b1};
    else               cnt_d = cnt_q;
    if (wr_en_i) begin
      case (idx_i)
        RG_CTRL: ctrl_d = wdata_i;
        RG_STAT: stat_d = {stat_q[7:5] & wdata_i[7:5], wdata_i[4:0]};
        RG_CMPA: cmpa_d = wdata_i;
        RG_CMPB: cmpb_d = wdata_i;
        RG_CNT:  cnt_d  = wdata_i;
        default: ;
      endcase
    end
    stat_d[ST_A]   = stat_d[ST_A]   | ge_a;
    stat_d[ST_B]   = stat_d[ST_B]   | ge_b;
    stat_d[ST_OVF] = stat_d[ST_OVF] | ovf_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      cmpa_q <= ALL1;
      cmpb_q <= ALL1;
      cnt_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    case (idx_i)
      RG_CTRL: rdata_o = ctrl_q;
      RG_STAT: rdata_o = stat_q;
      RG_CMPA: rdata_o = cmpa_q;
      RG_CMPB: rdata_o = cmpb_q;
      RG_CNT:  rdata_o = cnt_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_a_o   = stat_q[ST_A]   & ctrl_q[CT_IE_A];
  assign irq_b_o   = stat_q[ST_B]   & ctrl_q[CT_IE_B];
  assign irq_ovf_o = stat_q[ST_OVF] & ctrl_q[CT_IE_OVF];

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_sel && !wr_cnt) |=> $stable(cnt_q));
  p_ovf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_sel && !clr_now && !wr_cnt && cnt_q == ALL1) |=> (stat_q[ST_OVF] && cnt_q == '0));
  p_flag_a_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q[ST_A] && !ge_a) |=> !stat_q[ST_A]);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_now && !wr_cnt) |=> (cnt_q == '0 && !$rose(stat_q[ST_OVF])));
  p_cnt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata_i)));
endmodule

// File: rtl/tmr8_pair.sv
module tmr8_pair
  import tmr8_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = $clog2(NCH) + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    irq_cmpa,
  output logic [NCH-1:0]    irq_cmpb,
  output logic [NCH-1:0]    irq_ovf
);
  localparam int CH_W = ADDR_W - IDX_W;

  logic [2:0]        tick;
  logic [CH_W-1:0]   ch_sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ch_rd [NCH];

  assign ch_sel = addr[ADDR_W-1:IDX_W];
  assign idx    = addr[IDX_W-1:0];

  tmr8_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr8_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en && (ch_sel == CH_W'(g))),
      .idx_i     (idx),
      .wdata_i   (wdata),
      .rdata_o   (ch_rd[g]),
      .irq_a_o   (irq_cmpa[g]),
      .irq_b_o   (irq_cmpb[g]),
      .irq_ovf_o (irq_ovf[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++)
      if (ch_sel == CH_W'(i)) rdata = ch_rd[i];
  end
endmodule

// File: tb/tmr8_pair_tb_top.sv
module tmr8_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] irq_cmpa, irq_cmpb, irq_ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tmr8_pair dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_ctrl [2];
  logic [7:0] m_stat [2];
  logic [7:0] m_ca   [2];
  logic [7:0] m_cb   [2];
  logic [7:0] m_cnt  [2];
  int         mdiv;

  function automatic bit exp_tick(input logic [2:0] sel, input int d);
    case (sel)
      3'd1:    return (d % 8) == 7;
      3'd2:    return (d % 64) == 63;
      3'd3:    return d == 8191;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(input int ch, input int idx);
    case (idx)
      0: return m_ctrl[ch];
      1: return m_stat[ch];
      2: return m_ca[ch];
      3: return m_cb[ch];
      4: return m_cnt[ch];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_ctrl[c] = 8'h00; m_stat[c] = 8'h00; m_cnt[c] = 8'h00;
        m_ca[c] = 8'hFF; m_cb[c] = 8'hFF;
      end
      mdiv = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit t, ga, gb, clr, ovf;
        logic [7:0] nctrl, nstat, nca, ncb, ncnt;
        t   = exp_tick(m_ctrl[c][2:0], mdiv);
        ga  = m_cnt[c] >= m_ca[c];
        gb  = m_cnt[c] >= m_cb[c];
        clr = t && ((m_ctrl[c][4:3] == 2'b01 && ga) || (m_ctrl[c][4:3] == 2'b10 && gb));
        ovf = t && !clr && m_cnt[c] == 8'hFF;
        ncnt = clr ? 8'h00 : (t ? m_cnt[c] + 8'd1 : m_cnt[c]);
        nctrl = m_ctrl[c]; nstat = m_stat[c]; nca = m_ca[c]; ncb = m_cb[c];
        if (wr_en && int'(addr[3]) == c) begin
          case (addr[2:0])
            3'd0: nctrl = wdata;
            3'd1: nstat = {m_stat[c][7:5] & wdata[7:5], wdata[4:0]};
            3'd2: nca = wdata;
            3'd3: ncb = wdata;
            3'd4: ncnt = wdata;
            default: ;
          endcase
        end
        nstat[7:5] = nstat[7:5] | {gb, ga, ovf};
        m_ctrl[c] = nctrl; m_stat[c] = nstat; m_ca[c] = nca; m_cb[c] = ncb; m_cnt[c] = ncnt;
      end
      mdiv = (mdiv + 1) % 8192;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R8: interrupt lines against model every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        logic [2:0] e;
        e = {m_stat[c][7] & m_ctrl[c][7], m_stat[c][6] & m_ctrl[c][6], m_stat[c][5] & m_ctrl[c][5]};
        chk({irq_cmpb[c], irq_cmpa[c], irq_ovf[c]} == e, "R8 irq lines",
            int'({irq_cmpb[c], irq_cmpa[c], irq_ovf[c]}), int'(e));
      end
    end
  end

  task automatic rd_chk(input int ch, input int idx, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = {ch[0], idx[2:0]};
    #2;
    chk(rdata == exp_reg(ch, idx), tag, int'(rdata), int'(exp_reg(ch, idx)));
  endtask

  task automatic wr_now(input int ch, input int idx, input logic [7:0] d);
    wr_en = 1'b1; addr = {ch[0], idx[2:0]}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int ch, input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_now(ch, idx, d);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] v0, v1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset values, R10 unused indices
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) rd_chk(c, i, (i < 5) ? "R7 reset value" : "R10 unused index");

    // R5/R6: write all ones to status: sticky bits stay clear, plain bits set
    wr(0, 1, 8'hFF);
    rd_chk(0, 1, "R5 R6 status write ones");
    chk(exp_reg(0, 1) == 8'h1F, "R5 model status", int'(exp_reg(0, 1)), 8'h1F);
    wr(0, 5, 8'hAA);
    rd_chk(0, 5, "R10 write to unused index");
    wr(1, 2, 8'h3C); rd_chk(1, 2, "R6 compare A rw");
    wr(1, 2, 8'hFF);

    // R1/R3/R4: divide-by-8, clear on A at 5, compare A interrupt enabled
    wr(0, 2, 8'h05);
    wr(0, 0, 8'h49);
    for (int k = 0; k < 40; k++) begin
      idle(3);
      rd_chk(0, 4, "R1 R4 counter div8 clear-on-A");
      chk(exp_reg(0, 4) <= 8'h05, "R4 period bound", int'(exp_reg(0, 4)), 5);
    end
    rd_chk(0, 1, "R3 compare A flag");
    chk(irq_cmpa[0] == 1'b1, "R8 cmpa irq raised", int'(irq_cmpa[0]), 1);

    // R5: clearing flag while counter below compare A (write cnt first)
    wr(0, 0, 8'h40);
    wr(0, 4, 8'h00);
    wr(0, 1, 8'h1F);
    rd_chk(0, 1, "R5 sticky clear by zero");
    chk(exp_reg(0, 1)[6] == 1'b0, "R5 flag A cleared", int'(exp_reg(0, 1)), 8'h1F);

    // R4: divide-by-64, clear on B at 3
    wr(1, 3, 8'h03);
    wr(1, 0, 8'h92);
    for (int k = 0; k < 30; k++) begin
      idle(20);
      rd_chk(1, 4, "R1 R4 counter div64 clear-on-B");
    end
    rd_chk(1, 1, "R3 compare B flag");

    // R1: divide-by-8192 on channel 1
    wr(1, 3, 8'hFF);
    wr(1, 4, 8'h00);
    wr(1, 0, 8'h03);
    for (int k = 0; k < 6; k++) begin
      idle(4000);
      rd_chk(1, 4, "R1 counter div8192");
    end

    // R2: overflow wrap from 0xF0 with compares at 0xFF
    wr(0, 2, 8'hFF); wr(0, 3, 8'hFF);
    wr(0, 1, 8'h00);
    wr(0, 4, 8'hF0);
    wr(0, 0, 8'h21);
    idle(200);
    rd_chk(0, 1, "R2 overflow flag");
    chk(exp_reg(0, 1)[5] == 1'b1, "R2 overflow set", int'(exp_reg(0, 1)), 8'h20);
    rd_chk(0, 4, "R2 counter after wrap");
    chk(irq_ovf[0] == 1'b1, "R8 ovf irq raised", int'(irq_ovf[0]), 1);

    // R1: stopped select holds counter
    wr(0, 0, 8'h04);
    rd_chk(0, 4, "R1 stopped");
    v0 = rdata;
    idle(100);
    rd_chk(0, 4, "R1 stopped hold");
    v1 = rdata;
    chk(v0 == v1, "R1 stopped counter stable", int'(v1), int'(v0));

    // R9: counter write on a tick cycle wins
    wr(0, 0, 8'h01);
    do @(negedge clk); while ((mdiv % 8) != 7);
    wr_now(0, 4, 8'h77);
    rd_chk(0, 4, "R9 write wins over tick");
    chk(rdata == 8'h77, "R9 literal value", int'(rdata), 8'h77);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op, ch, idx;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      ch = int'($urandom_range(0, 1));
      idx = int'($urandom_range(0, 7));
      d = 8'($urandom);
      if (op < 3) begin
        if (idx == 0) d[2:0] = 3'($urandom_range(0, 2));
        wr(ch, idx, d);
      end else if (op < 8) begin
        rd_chk(ch, idx, "R2 R3 R4 R5 R6 random read");
      end else begin
        idle(int'($urandom_range(1, 30)));
      end
    end

    finish_run();
  end
endmodule